// File: doc/BRIEF.md
# Character LCD Power-Up Sequencer

This block brings a serial character-LCD controller out of power-up without help from software. As soon as reset is released it walks through a fixed list of eight setup commands and hands every byte to an external byte-level I2C master. Each command is one bus transaction made of three bytes:

- the device address byte, which opens the transaction with a start condition;
- a control byte of 0x00, which tells the display controller that an instruction follows;
- the instruction itself, which closes the transaction with a stop condition.

The second command switches the display controller to its extended instruction table. The oscillator, contrast, power/icon and follower commands that come after it are decoded from that table. The run then switches the display on and clears it.

A build parameter picks the 3.3 V or the 5 V variant of the list. The two variants differ only in the contrast, power/icon and follower bytes. After each command the sequencer stays off the bus for a set number of clock cycles. The clear-display command gets a longer wait than the others. The follower command gets the longest wait, which lets the LCD drive voltage settle. Every wait must be at least one cycle.

When the last wait has run out, a done flag goes high. If the master reports a refused byte, the run stops and an error flag goes high instead. A start pulse given after the run has ended, whether it finished or failed, repeats the whole list from the first command.

Top module: `lcd_init_seq`

## Requirements
- R1: While reset is asserted, reqValid, seqDone and seqError are all low. After reset is released, the sequence begins by itself at the first command, without a start pulse.
- R2: Each command is sent as three requests in this order: the byte {BUS_ADDR, 1'b0} (0x7C by default) with reqStart high; then 0x00 with reqStart and reqStop both low; then the command byte with reqStop high.
- R3: With SUPPLY_5V = 0, the command bytes are 0x38, 0x39, 0x14, 0x74, 0x54, 0x6F, 0x0C, 0x01, in that order.
- R4: With SUPPLY_5V = 1, the command bytes are 0x38, 0x39, 0x14, 0x79, 0x50, 0x6C, 0x0C, 0x01, in that order.
- R5: Once reqValid is high, it stays high, and reqByte, reqStart and reqStop hold their values, until a cycle in which rspDone is high.
- R6: After a command byte is accepted (rspDone high, rspNack low), reqValid stays low for exactly the wait that belongs to that command: WAIT_SETTLE cycles after the 6th command (follower, 0x6F or 0x6C), WAIT_CLEAR cycles after the 8th command (0x01), and WAIT_SHORT cycles after every other command.
- R7: seqDone goes high in the cycle after the wait of the last command ends. It then stays high, with reqValid low, until a start pulse arrives.
- R8: A runStart pulse seen while seqDone or seqError is high clears both flags on the next cycle. The next cycle also presents the first request of the first command.
- R9: A runStart pulse that arrives while a run is in progress has no effect: the byte stream carries on unchanged.
- R10: A cycle with rspDone and rspNack both high ends the run. In the next cycle seqError is high and reqValid is low. Both stay that way, and seqDone stays low, until a start pulse arrives.
- R11: Asserting reset in the middle of a run abandons that run. The next run, which begins after reset is released, starts again from the first command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| runStart | input | 1 | One-cycle pulse that repeats the sequence after it has ended |
| reqValid | output | 1 | A byte request is presented to the I2C master |
| reqByte | output | 8 | The byte to transmit |
| reqStart | output | 1 | Send a start condition before this byte |
| reqStop | output | 1 | Send a stop condition after this byte |
| rspDone | input | 1 | The master has finished the current byte (one-cycle pulse) |
| rspNack | input | 1 | Valid together with rspDone: the byte was not acknowledged |
| seqDone | output | 1 | The whole sequence has completed |
| seqError | output | 1 | The sequence was aborted by a refused byte |

## Verification
The hardest case to reach from the ports is a refusal that lands on one chosen byte in the middle of a run, or a start pulse that arrives while a byte is still waiting to be acknowledged. Neither can be timed from outside without knowing exactly where the byte stream stands. The bench's bus model therefore counts every handshake it completes. It refuses the handshake whose number the stimulus selects, which places the NACK on the command byte of the second command. A configurable answer latency keeps each request pending for several cycles, so that the hold checks and the mid-run start pulse hit real outstanding requests. The same model also times the quiet gap after every stop byte, so each of the three wait lengths is measured directly at the ports.

// File: rtl/lcd_init_pkg.sv
package lcd_init_pkg;

  // Length of the setup list and the positions that carry the longer waits
  localparam int CMD_COUNT  = 8;
  localparam int IDX_W      = $clog2(CMD_COUNT);
  localparam int SETTLE_POS = 5;
  localparam int CLEAR_POS  = 7;

  // Which of the three bytes of a transaction is presented
  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_CMD  = 2'd2
  } byte_sel_t;

  // Wait class that follows a command
  typedef enum logic [1:0] {
    HOLD_SHORT  = 2'd0,
    HOLD_CLEAR  = 2'd1,
    HOLD_SETTLE = 2'd2
  } hold_kind_t;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    byte_sel_t sel;
    logic      clrIdx;
    logic      incIdx;
    logic      loadWait;
    logic      decWait;
  } dp_strobe_t;

endpackage

// File: rtl/lcd_cmd_rom.sv
module lcd_cmd_rom
  import lcd_init_pkg::*;
#(
  parameter bit SUPPLY_5V = 1'b0
) (
  input  logic [IDX_W-1:0] idx,
  output logic [7:0]       cmd,
  output hold_kind_t       holdKind
);

  // The three supply-dependent tuning bytes of the extended table
  logic [7:0] contrastLo;
  logic [7:0] powerIcon;
  logic [7:0] follower;

  generate
    if (SUPPLY_5V) begin : g_supply5v
      assign contrastLo = 8'h79;
      assign powerIcon  = 8'h50;
      assign follower   = 8'h6C;
    end else begin : g_supply3v3
      assign contrastLo = 8'h74;
      assign powerIcon  = 8'h54;
      assign follower   = 8'h6F;
    end
  endgenerate

  always_comb begin
    case (idx)
      3'd0:    cmd = 8'h38;       // 8-bit, two lines, normal table
      3'd1:    cmd = 8'h39;       // same, extended table selected
      3'd2:    cmd = 8'h14;       // oscillator trim
      3'd3:    cmd = contrastLo;
      3'd4:    cmd = powerIcon;
      3'd5:    cmd = follower;
      3'd6:    cmd = 8'h0C;       // display on
      default: cmd = 8'h01;       // clear display
    endcase
  end

  always_comb begin
    if (idx == IDX_W'(SETTLE_POS))     holdKind = HOLD_SETTLE;
    else if (idx == IDX_W'(CLEAR_POS)) holdKind = HOLD_CLEAR;
    else                               holdKind = HOLD_SHORT;
  end

endmodule

// File: rtl/lcd_init_dp.sv
module lcd_init_dp
  import lcd_init_pkg::*;
#(
  parameter bit          SUPPLY_5V   = 1'b0,
  parameter logic [6:0]  BUS_ADDR    = 7'h3E,
  parameter int unsigned WAIT_SHORT  = 3000,
  parameter int unsigned WAIT_CLEAR  = 160000,
  parameter int unsigned WAIT_SETTLE = 20000000
) (
  input  logic       clk,
  input  logic       rstN,
  input  dp_strobe_t stb,
  output logic [7:0] txByte,
  output logic       lastCmd,
  output logic       waitDone
);

  localparam int unsigned WAIT_MAX_SC = (WAIT_SHORT > WAIT_CLEAR) ? WAIT_SHORT : WAIT_CLEAR;
  localparam int unsigned WAIT_MAX    = (WAIT_MAX_SC > WAIT_SETTLE) ? WAIT_MAX_SC : WAIT_SETTLE;
  localparam int          WAIT_W      = $clog2(WAIT_MAX + 1);
  localparam logic [WAIT_W-1:0] LOAD_SHORT  = WAIT_W'(WAIT_SHORT - 1);
  localparam logic [WAIT_W-1:0] LOAD_CLEAR  = WAIT_W'(WAIT_CLEAR - 1);
  localparam logic [WAIT_W-1:0] LOAD_SETTLE = WAIT_W'(WAIT_SETTLE - 1);

  logic [IDX_W-1:0]  cmdIdx;
  logic [WAIT_W-1:0] waitCnt;
  logic [WAIT_W-1:0] loadVal;
  logic [7:0]        romCmd;
  hold_kind_t        holdKind;

  lcd_cmd_rom #(.SUPPLY_5V(SUPPLY_5V)) u_rom (
    .idx      (cmdIdx),
    .cmd      (romCmd),
    .holdKind (holdKind)
  );

  // Command pointer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           cmdIdx <= '0;
    else if (stb.clrIdx) cmdIdx <= '0;
    else if (stb.incIdx) cmdIdx <= cmdIdx + 1'b1;
  end

  assign lastCmd = (cmdIdx == IDX_W'(CMD_COUNT - 1));

  // Post-command wait: loaded with length-1, so the wait state lasts exactly the length
  always_comb begin
    case (holdKind)
      HOLD_SETTLE: loadVal = LOAD_SETTLE;
      HOLD_CLEAR:  loadVal = LOAD_CLEAR;
      default:     loadVal = LOAD_SHORT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                             waitCnt <= '0;
    else if (stb.loadWait)                 waitCnt <= loadVal;
    else if (stb.decWait && waitCnt != 0)  waitCnt <= waitCnt - 1'b1;
  end

  assign waitDone = (waitCnt == '0);

  // Byte selection for the three phases of a transaction
  always_comb begin
    case (stb.sel)
      SEL_ADDR: txByte = {BUS_ADDR, 1'b0};
      SEL_CTRL: txByte = 8'h00;
      default:  txByte = romCmd;
    endcase
  end

  // The controller never advances past the last command
  assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!rstN)
    stb.incIdx |-> !lastCmd);

  // The controller only counts down a live wait
  assert_live_count_R6: assert property (@(posedge clk) disable iff (!rstN)
    stb.decWait |-> !waitDone);

endmodule

// File: rtl/lcd_init_ctrl.sv
module lcd_init_ctrl
  import lcd_init_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       runStart,
  input  logic       rspDone,
  input  logic       rspNack,
  input  logic       lastCmd,
  input  logic       waitDone,
  output dp_strobe_t stb,
  output logic       reqValid,
  output logic       reqStart,
  output logic       reqStop,
  output logic       seqDone,
  output logic       seqError
);

  typedef enum logic [2:0] {
    ST_BOOT = 3'd0,
    ST_ADDR = 3'd1,
    ST_CTRL = 3'd2,
    ST_CMD  = 3'd3,
    ST_HOLD = 3'd4,
    ST_DONE = 3'd5,
    ST_FAIL = 3'd6
  } seq_state_t;

  seq_state_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_BOOT;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext    = state;
    stb          = '0;
    stb.sel      = SEL_CMD;
    case (state)
      ST_BOOT: begin
        stb.clrIdx = 1'b1;
        stateNext  = ST_ADDR;
      end
      ST_ADDR: begin
        stb.sel = SEL_ADDR;
        if (rspDone) stateNext = rspNack ? ST_FAIL : ST_CTRL;
      end
      ST_CTRL: begin
        stb.sel = SEL_CTRL;
        if (rspDone) stateNext = rspNack ? ST_FAIL : ST_CMD;
      end
      ST_CMD: begin
        if (rspDone) begin
          if (rspNack) begin
            stateNext = ST_FAIL;
          end else begin
            stb.loadWait = 1'b1;
            stateNext    = ST_HOLD;
          end
        end
      end
      ST_HOLD: begin
        if (waitDone) begin
          if (lastCmd) begin
            stateNext = ST_DONE;
          end else begin
            stb.incIdx = 1'b1;
            stateNext  = ST_ADDR;
          end
        end else begin
          stb.decWait = 1'b1;
        end
      end
      ST_DONE, ST_FAIL: begin
        if (runStart) begin
          stb.clrIdx = 1'b1;
          stateNext  = ST_ADDR;
        end
      end
      default: stateNext = ST_BOOT;
    endcase
  end

  assign reqValid = (state == ST_ADDR) || (state == ST_CTRL) || (state == ST_CMD);
  assign reqStart = (state == ST_ADDR);
  assign reqStop  = (state == ST_CMD);
  assign seqDone  = (state == ST_DONE);
  assign seqError = (state == ST_FAIL);

  assert_nack_abort_R10: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && rspDone && rspNack) |=> (seqError && !reqValid && !seqDone));

  assert_fail_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (seqError && !runStart) |=> (seqError && !reqValid));

  assert_done_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (seqDone && !runStart) |=> (seqDone && !reqValid));

  assert_restart_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((seqDone || seqError) && runStart) |=> (reqValid && reqStart && !seqDone && !seqError));

  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !rspDone && runStart) |=> reqValid);

endmodule

// File: rtl/lcd_init_seq.sv
module lcd_init_seq
  import lcd_init_pkg::*;
#(
  parameter bit          SUPPLY_5V   = 1'b0,
  parameter logic [6:0]  BUS_ADDR    = 7'h3E,
  parameter int unsigned WAIT_SHORT  = 3000,
  parameter int unsigned WAIT_CLEAR  = 160000,
  parameter int unsigned WAIT_SETTLE = 20000000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       runStart,
  output logic       reqValid,
  output logic [7:0] reqByte,
  output logic       reqStart,
  output logic       reqStop,
  input  logic       rspDone,
  input  logic       rspNack,
  output logic       seqDone,
  output logic       seqError
);

  dp_strobe_t stb;
  logic       lastCmd;
  logic       waitDone;

  lcd_init_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .runStart (runStart),
    .rspDone  (rspDone),
    .rspNack  (rspNack),
    .lastCmd  (lastCmd),
    .waitDone (waitDone),
    .stb      (stb),
    .reqValid (reqValid),
    .reqStart (reqStart),
    .reqStop  (reqStop),
    .seqDone  (seqDone),
    .seqError (seqError)
  );

  lcd_init_dp #(
    .SUPPLY_5V   (SUPPLY_5V),
    .BUS_ADDR    (BUS_ADDR),
    .WAIT_SHORT  (WAIT_SHORT),
    .WAIT_CLEAR  (WAIT_CLEAR),
    .WAIT_SETTLE (WAIT_SETTLE)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .txByte   (reqByte),
    .lastCmd  (lastCmd),
    .waitDone (waitDone)
  );

  assert_req_stable_R5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !rspDone) |=> (reqValid && $stable(reqByte) && $stable(reqStart) && $stable(reqStop)));

  assert_first_addr_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqValid) |-> (reqStart && reqByte == {BUS_ADDR, 1'b0}));

endmodule

// File: tb/lcd_init_seq_bench.sv
module lcd_init_seq_bench;

  localparam int WS = 4;
  localparam int WC = 9;
  localparam int WF = 15;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  // Main instance, 3.3 V list
  logic       rstN, runStart, rspDone, rspNack;
  logic       reqValid, reqStart, reqStop, seqDone, seqError;
  logic [7:0] reqByte;

  // Second instance, 5 V list
  logic       rstN5, rspDone5;
  logic       reqValid5, reqStart5, reqStop5, seqDone5, seqError5;
  logic [7:0] reqByte5;

  lcd_init_seq #(.SUPPLY_5V(1'b0), .WAIT_SHORT(WS), .WAIT_CLEAR(WC), .WAIT_SETTLE(WF)) u_lcd_init_seq (
    .clk(clk), .rstN(rstN), .runStart(runStart),
    .reqValid(reqValid), .reqByte(reqByte), .reqStart(reqStart), .reqStop(reqStop),
    .rspDone(rspDone), .rspNack(rspNack), .seqDone(seqDone), .seqError(seqError));

  lcd_init_seq #(.SUPPLY_5V(1'b1), .WAIT_SHORT(WS), .WAIT_CLEAR(WC), .WAIT_SETTLE(WF)) u_lcd_init_seq_5v (
    .clk(clk), .rstN(rstN5), .runStart(1'b0),
    .reqValid(reqValid5), .reqByte(reqByte5), .reqStart(reqStart5), .reqStop(reqStop5),
    .rspDone(rspDone5), .rspNack(1'b0), .seqDone(seqDone5), .seqError(seqError5));

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  typedef struct packed {
    logic [7:0]  b;
    logic        s;
    logic        p;
    logic [31:0] gap;
  } item_t;

  item_t expQ[$];
  int lat    = 0;
  int nackAt = -1;
  int hsCnt  = 0;

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] cmdOf(input bit v5, input int i);
    case (i)
      0: return 8'h38;
      1: return 8'h39;
      2: return 8'h14;
      3: return v5 ? 8'h79 : 8'h74;
      4: return v5 ? 8'h50 : 8'h54;
      5: return v5 ? 8'h6C : 8'h6F;
      6: return 8'h0C;
      default: return 8'h01;
    endcase
  endfunction

  function automatic int gapOf(input int i);
    if (i == 5) return WF;
    if (i == 7) return WC;
    return WS;
  endfunction

  // Driver: pushes the expected byte stream of one full run
  task automatic pushSeq();
    for (int i = 0; i < 8; i++) begin
      expQ.push_back('{b: 8'h7C, s: 1'b1, p: 1'b0, gap: 32'd0});
      expQ.push_back('{b: 8'h00, s: 1'b0, p: 1'b0, gap: 32'd0});
      expQ.push_back('{b: cmdOf(1'b0, i), s: 1'b0, p: 1'b1, gap: 32'(gapOf(i))});
    end
  endtask

  // Monitor and bus model: pops and compares, answers, times the gaps
  initial begin
    bit    inByte;
    bit    gapActive;
    int    latCnt;
    int    gapCnt;
    int    expGap;
    item_t cur;
    logic [9:0] cap;
    inByte = 0; gapActive = 0; latCnt = 0; gapCnt = 0; expGap = 0; cap = '0; cur = '0;
    rspDone = 1'b0;
    rspNack = 1'b0;
    forever begin
      @(negedge clk);
      rspDone = 1'b0;
      rspNack = 1'b0;
      if (!rstN) begin
        inByte = 0;
        gapActive = 0;
        continue;
      end
      if (gapActive) begin
        if (reqValid || seqDone || seqError) begin
          check(gapCnt == expGap, "R6", "wait cycles after command", gapCnt, expGap);
          gapActive = 0;
        end else begin
          gapCnt++;
        end
      end
      if (reqValid && !gapActive) begin
        if (!inByte) begin
          inByte = 1;
          latCnt = lat;
          cap = {reqByte, reqStart, reqStop};
          if (expQ.size() == 0) begin
            check(1'b0, "R9", "unexpected request", int'(cap), 0);
            cur = '0;
          end else begin
            cur = expQ.pop_front();
            check(cap == {cur.b, cur.s, cur.p}, cur.p ? "R3" : "R2", "request {byte,start,stop}",
                  int'(cap), int'({cur.b, cur.s, cur.p}));
          end
        end else begin
          check({reqByte, reqStart, reqStop} == cap, "R5", "held request",
                int'({reqByte, reqStart, reqStop}), int'(cap));
        end
        if (latCnt == 0) begin
          rspDone = 1'b1;
          inByte = 0;
          if (hsCnt == nackAt) rspNack = 1'b1;
          hsCnt++;
          if (cap[0] && !rspNack) begin
            gapActive = 1;
            gapCnt = 0;
            expGap = int'(cur.gap);
          end
        end else begin
          latCnt--;
        end
      end
    end
  end

  // 5 V instance: immediate answers, byte log
  logic [7:0] log5 [32];
  int n5 = 0;
  initial begin
    rspDone5 = 1'b0;
    forever begin
      @(negedge clk);
      if (rspDone5) rspDone5 = 1'b0;
      else if (rstN5 && reqValid5) begin
        if (n5 < 32) log5[n5] = reqByte5;
        n5++;
        rspDone5 = 1'b1;
      end
    end
  end

  initial begin
    rstN5 = 1'b0;
    repeat (3) @(posedge clk);
    #2 rstN5 = 1'b1;
  end

  task automatic pulseStart();
    @(posedge clk); #2 runStart = 1'b1;
    @(posedge clk); #2 runStart = 1'b0;
  endtask

  task automatic waitEnd();
    do @(negedge clk); while (!(seqDone || seqError));
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL R7 watchdog: actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    runStart = 1'b0;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(!reqValid && !seqDone && !seqError, "R1", "outputs in reset",
          int'({reqValid, seqDone, seqError}), 0);
    // R1: self-start after reset, full 3.3 V run (R2, R3, R6 via monitor)
    pushSeq();
    @(posedge clk); #2 rstN = 1'b1;
    waitEnd();
    check(seqDone && !seqError, "R7", "done after first run", int'({seqDone, seqError}), 2);
    check(expQ.size() == 0, "R1", "bytes left after run", expQ.size(), 0);

    // R7: done holds, bus idle
    begin
      bit ok = 1'b1;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (!seqDone || reqValid) ok = 1'b0;
      end
      check(ok, "R7", "done held with bus idle", 0, 1);
    end

    // R8: restart from done, with slow answers; R9: mid-run start pulse ignored
    lat = 3;
    pushSeq();
    @(posedge clk); #2 runStart = 1'b1;
    @(posedge clk); #2 runStart = 1'b0;
    @(negedge clk);
    check(!seqDone && reqValid && reqStart, "R8", "restart from done",
          int'({seqDone, reqValid, reqStart}), 3);
    repeat (30) @(negedge clk);
    pulseStart();
    repeat (7) @(negedge clk);
    pulseStart();
    waitEnd();
    check(seqDone && !seqError, "R9", "run completes despite start pulses", int'({seqDone, seqError}), 2);
    check(expQ.size() == 0, "R9", "bytes left after run", expQ.size(), 0);

    // R10: refuse the command byte of the second command (handshake 5 of the run)
    nackAt = hsCnt + 5;
    pushSeq();
    pulseStart();
    waitEnd();
    @(negedge clk);
    check(seqError && !seqDone, "R10", "error after nack", int'({seqError, seqDone}), 2);
    check(expQ.size() == 18, "R10", "bytes left after abort", expQ.size(), 18);
    expQ.delete();
    begin
      bit ok = 1'b1;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (reqValid || !seqError || seqDone) ok = 1'b0;
      end
      check(ok, "R10", "bus idle while failed", 0, 1);
    end
    nackAt = -1;

    // R8: restart from error
    lat = 1;
    pushSeq();
    @(posedge clk); #2 runStart = 1'b1;
    @(posedge clk); #2 runStart = 1'b0;
    @(negedge clk);
    check(!seqError && reqValid && reqStart && reqByte == 8'h7C, "R8", "restart from error",
          int'({seqError, reqValid, reqStart}), 3);
    waitEnd();
    check(seqDone && !seqError, "R8", "done after restart", int'({seqDone, seqError}), 2);
    check(expQ.size() == 0, "R8", "bytes left after run", expQ.size(), 0);

    // R11: reset in the middle of a run
    lat = 0;
    pushSeq();
    pulseStart();
    repeat (40) @(negedge clk);
    @(posedge clk); #2 rstN = 1'b0;
    expQ.delete();
    repeat (3) @(negedge clk);
    check(!reqValid && !seqDone && !seqError, "R1", "outputs in mid-run reset",
          int'({reqValid, seqDone, seqError}), 0);
    pushSeq();
    @(posedge clk); #2 rstN = 1'b1;
    waitEnd();
    check(seqDone && !seqError, "R11", "done after reset restart", int'({seqDone, seqError}), 2);
    check(expQ.size() == 0, "R11", "bytes left after run", expQ.size(), 0);

    // R4: 5 V instance stream
    check(n5 == 24, "R4", "5V byte count", n5, 24);
    check(seqDone5 && !seqError5, "R4", "5V done", int'({seqDone5, seqError5}), 2);
    for (int k = 0; k < 24 && k < n5; k++) begin
      logic [7:0] e;
      case (k % 3)
        0: e = 8'h7C;
        1: e = 8'h00;
        default: e = cmdOf(1'b1, k / 3);
      endcase
      check(log5[k] == e, "R4", "5V byte", log5[k], e);
    end

    if (!finished) begin
      finished = 1'b1;
      summary();
      $finish;
    end
  end

endmodule